// File: doc/BRIEF.md
# Two-Bank Level Interrupt Combiner

This block gathers 64 level-sensitive peripheral interrupt lines and 8 level-sensitive local lines. It reduces them to two outputs for a processor: a normal interrupt line and a fast interrupt line. Software reaches it through a word-wide register port with a single write strobe and a combinational read path. Enables are never written directly. One group of registers sets enable bits where the written word has ones, and a second group clears them.

A summary register gives the enabled local lines, one flag for each half of the peripheral bank, and copies of eleven peripheral lines that are often serviced. With it, software can usually dispatch after one read.

The fast output follows one raw source that a 7-bit index selects. It does not use the enable masks. Both outputs are combinational from the input levels and the register state.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, every peripheral and local enable is 0, the fast enable is 0 and the fast index is 0. A read of control offset 0x0C then returns 0, and both outputs are low.
- R2: A write to enable-set offset 0x10 (peripheral 31..0), 0x14 (peripheral 63..32) or 0x18 (local 7..0) ORs the written word into that enable bank. Only wdata[7:0] is used for the local bank.
- R3: A write to enable-clear offset 0x1C, 0x20 or 0x24 clears each enable bit of the matching bank (same bank order as R2) where the written word has a one. Only wdata[7:0] is used for the local bank.
- R4: A read of an enable-set offset returns the enable bank, zero-extended for the local bank. A read of an enable-clear offset returns the bitwise inverse of the same bank.
- R5: A read of offset 0x04 returns peripheral levels 31..0 ANDed with their enables. A read of offset 0x08 does the same for levels 63..32.
- R6: The summary register at offset 0x00 holds the enabled local levels in bits 7:0. Bit 8 is the OR of the enabled peripheral levels 31..0, and bit 9 is the OR of the enabled peripheral levels 63..32.
- R7: Summary bits 10 to 20 hold the enabled pending state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62. Bit 10 holds line 7, and the lines follow in that order. Bits 31:21 read 0.
- R8: A write to offset 0x0C stores wdata[6:0] as the fast index and wdata[7] as the fast enable. A read returns them in the same bit positions, with zeros above.
- R9: When the fast enable is set, an index below 64 puts raw peripheral line index on the fast output. An index from 64 to 71 puts raw local line (index−64) there, and an index of 72 or more gives 0. Enables do not affect this path. When the fast enable is clear, the fast output is low.
- R10: The normal interrupt output is high exactly when some peripheral or local line is high while its enable is set.
- R11: A read of any offset not listed above returns 0. A write to an unlisted offset, or to 0x00, 0x04 or 0x08, changes no register state.
- R12: Both outputs follow an input level change without any clock edge. They reflect an enable or control write as soon as the clock edge that stores it has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_lvl | input | 64 | Peripheral interrupt levels |
| loc_lvl | input | 8 | Local interrupt levels |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq_out | output | 1 | Normal interrupt output |
| fiq_out | output | 1 | Fast interrupt output |

## Verification
The bench targets the fast path at the bank boundary, with indices 63, 64, 71 and 72. An off-by-one in the select would route the wrong bank or leak a local line that does not exist. It checks that a set write keeps enables already set and that a clear write touches only the ones written. A design that assigned the enable register directly would lose earlier bits. It also writes to the read-only pending offsets and to an unmapped offset. A loose decoder would quietly change the enables there. The summary copies are driven one line at a time against the listed order, to show a shifted or reversed mapping.

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       per_lvl,
  input  logic [7:0]        loc_lvl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam logic [ADDR_W-1:0] A_SUM    = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_PND_LO = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_PND_HI = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_FAST   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_SET_LO = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_SET_HI = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_SET_LC = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_CLR_LO = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_CLR_HI = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_CLR_LC = ADDR_W'('h24);
  localparam int NDUP = 11;
  localparam int DUP_LINE [NDUP] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

  logic [63:0] en_per;
  logic [7:0]  en_loc;
  logic        fq_en;
  logic [6:0]  fq_sel;

  logic [63:0] pend;
  logic [7:0]  lpend;
  logic [NDUP-1:0] dup;
  logic [31:0] summary;
  logic        fast_src;

  assign pend  = per_lvl & en_per;
  assign lpend = loc_lvl & en_loc;

  always_comb begin
    for (int i = 0; i < NDUP; i++) dup[i] = pend[DUP_LINE[i]];
  end

  assign summary = {11'd0, dup, |pend[63:32], |pend[31:0], lpend};

  always_comb begin
    if (!fq_sel[6])           fast_src = per_lvl[fq_sel[5:0]];
    else if (fq_sel[5:3] == 0) fast_src = loc_lvl[fq_sel[2:0]];
    else                      fast_src = 1'b0;
  end

  assign fiq_out = fq_en & fast_src;
  assign irq_out = (|pend) | (|lpend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_per <= '0;
      en_loc <= '0;
      fq_en  <= 1'b0;
      fq_sel <= '0;
    end else if (wr_en) begin
      case (addr)
        A_FAST: begin
          fq_sel <= wdata[6:0];
          fq_en  <= wdata[7];
        end
        A_SET_LO: en_per[31:0]  <= en_per[31:0]  | wdata;
        A_SET_HI: en_per[63:32] <= en_per[63:32] | wdata;
        A_SET_LC: en_loc        <= en_loc        | wdata[7:0];
        A_CLR_LO: en_per[31:0]  <= en_per[31:0]  & ~wdata;
        A_CLR_HI: en_per[63:32] <= en_per[63:32] & ~wdata;
        A_CLR_LC: en_loc        <= en_loc        & ~wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_SUM:    rdata = summary;
      A_PND_LO: rdata = pend[31:0];
      A_PND_HI: rdata = pend[63:32];
      A_FAST:   rdata = {24'd0, fq_en, fq_sel};
      A_SET_LO: rdata = en_per[31:0];
      A_SET_HI: rdata = en_per[63:32];
      A_SET_LC: rdata = {24'd0, en_loc};
      A_CLR_LO: rdata = ~en_per[31:0];
      A_CLR_HI: rdata = ~en_per[63:32];
      A_CLR_LC: rdata = ~{24'd0, en_loc};
      default:  rdata = '0;
    endcase
  end
endmodule

module irq_bank_ctrl_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [63:0]       en_per,
  input logic [7:0]        en_loc,
  input logic              fq_en,
  input logic [6:0]        fq_sel,
  input logic              irq_out,
  input logic              fiq_out
);
  // R2
  set_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h10)) |=> ((en_per[31:0] & $past(wdata)) == $past(wdata)));
  // R3
  clr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h20)) |=> ((en_per[63:32] & $past(wdata)) == 32'd0));
  // R11
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h00)) |=>
      ($stable(en_per) && $stable(en_loc) && $stable(fq_en) && $stable(fq_sel)));
  // R9
  fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fq_en |-> !fiq_out);
  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_per == 64'd0 && en_loc == 8'd0) |-> !irq_out);
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .en_per(en_per), .en_loc(en_loc), .fq_en(fq_en), .fq_sel(fq_sel),
  .irq_out(irq_out), .fiq_out(fiq_out)
);

// File: tb/irq_bank_ctrl_bench.sv
`timescale 1ns/1ps
module irq_bank_ctrl_bench;
  localparam int AW = 9;
  localparam logic [AW-1:0] O_SUM = 9'h00, O_PLO = 9'h04, O_PHI = 9'h08, O_FST = 9'h0C,
    O_SLO = 9'h10, O_SHI = 9'h14, O_SLC = 9'h18, O_CLO = 9'h1C, O_CHI = 9'h20, O_CLC = 9'h24;

  typedef struct packed {
    logic [7:0]  ctl;
    logic [63:0] per;
    logic [7:0]  loc;
    logic        exp;
  } fvec_t;

  localparam fvec_t FV [8] = '{
    '{8'h05, 64'h20, 8'h00, 1'b0},
    '{8'h85, 64'h20, 8'h00, 1'b1},
    '{8'h85, 64'h00, 8'hFF, 1'b0},
    '{8'hBF, 64'h8000_0000_0000_0000, 8'h00, 1'b1},
    '{8'hC0, 64'h0, 8'h01, 1'b1},
    '{8'hC7, 64'h0, 8'h80, 1'b1},
    '{8'hC8, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0},
    '{8'h80, 64'h1, 8'h00, 1'b1}
  };

  localparam int DUPS [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [63:0] per_lvl = '0;
  logic [7:0]  loc_lvl = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq_out, fiq_out;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_bank_ctrl #(.ADDR_W(AW)) u_irq_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .per_lvl(per_lvl), .loc_lvl(loc_lvl), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .fiq_out(fiq_out));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req, input logic [31:0] exp);
    addr = a; #1; check(req, rdata, exp);
  endtask

  function automatic logic [31:0] model_sum(input logic [63:0] p, input logic [63:0] e,
                                            input logic [7:0] l, input logic [7:0] le);
    logic [63:0] q = p & e;
    logic [31:0] s = {22'd0, |q[63:32], |q[31:0], l & le};
    for (int i = 0; i < 11; i++) s[10+i] = q[DUPS[i]];
    return s;
  endfunction

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] m_en;
    logic [7:0]  m_lc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(O_FST, "R1 ctrl", 32'h0);
    rd(O_SLO, "R1 en lo", 32'h0);
    rd(O_SLC, "R1 en loc", 32'h0);
    check("R1 outputs", {irq_out, fiq_out}, 2'b00);
    // R4 inverse after reset
    rd(O_CLO, "R4 clr lo", 32'hFFFF_FFFF);
    rd(O_CLC, "R4 clr loc", 32'hFFFF_FFFF);

    // R9 table walk: raw routing
    for (int i = 0; i < 8; i++) begin
      wr(O_FST, {24'd0, FV[i].ctl});
      per_lvl = FV[i].per; loc_lvl = FV[i].loc; #1;
      check($sformatf("R9 vec%0d", i), fiq_out, FV[i].exp);
    end
    // R8 control readback, upper bits dropped
    wr(O_FST, 32'hFFFF_FF45);
    rd(O_FST, "R8 ctrl rd", 32'h45);
    per_lvl = '0; loc_lvl = '0;

    // R2 set keeps earlier bits
    wr(O_SLO, 32'h81);
    wr(O_SLO, 32'h100);
    rd(O_SLO, "R2 set lo", 32'h181);
    wr(O_SLC, 32'hFFFF_FF0F);
    rd(O_SLC, "R2 set loc low byte", 32'h0F);
    // R3 clear
    wr(O_CLO, 32'h1);
    rd(O_SLO, "R3 clr lo", 32'h180);
    wr(O_CLC, 32'hFFFF_FF03);
    rd(O_SLC, "R3 clr loc", 32'h0C);
    rd(O_CLO, "R4 clr lo inverse", ~32'h180);
    rd(O_CLC, "R4 clr loc inverse", ~32'h0C);
    m_lc = 8'h0C;

    // R12 irq follows inputs without a clock edge
    @(negedge clk); per_lvl[7] = 1'b1; #1;
    check("R12 irq rise", irq_out, 1'b1);
    per_lvl[7] = 1'b0; #1;
    check("R10 irq fall", irq_out, 1'b0);
    loc_lvl = 8'h01; #1;
    check("R10 disabled local", irq_out, 1'b0);
    loc_lvl = 8'h04; #1;
    check("R10 enabled local", irq_out, 1'b1);
    loc_lvl = 0;

    // R5/R6/R7 full enables, one dup line at a time
    wr(O_SLO, 32'hFFFF_FFFF);
    wr(O_SHI, 32'hFFFF_FFFF);
    m_en = '1;
    for (int i = 0; i < 11; i++) begin
      per_lvl = 64'd1 << DUPS[i];
      rd(O_SUM, $sformatf("R7 dup line %0d", DUPS[i]), model_sum(per_lvl, m_en, 0, m_lc));
    end
    per_lvl = 64'h0000_0001_0000_0000; loc_lvl = 8'hFF;
    rd(O_SUM, "R6 hi flag and local", model_sum(per_lvl, m_en, loc_lvl, m_lc));
    // R12 enable write reflected after the storing edge
    wr(O_CHI, 32'hFFFF_FFFF);
    wr(O_CLC, 32'hFF);
    m_en[63:32] = 0; m_lc = 0; loc_lvl = 0;
    check("R12 irq after clear", irq_out, 1'b0);
    per_lvl = 64'hA5A5_0000_5A5A_0001;
    wr(O_SHI, 32'hF000_0000);
    m_en[63:32] = 32'hF000_0000;
    rd(O_PLO, "R5 pend lo", 32'h5A5A_0001);
    rd(O_PHI, "R5 pend hi", 32'hA000_0000);
    rd(O_SUM, "R6 summary mix", model_sum(per_lvl, m_en, 0, m_lc));

    // R11 unmapped and read-only
    rd(9'h028, "R11 unmapped rd", 32'h0);
    rd(9'h1FC, "R11 far rd", 32'h0);
    wr(O_PLO, 32'hFFFF_FFFF);
    wr(O_SUM, 32'hFFFF_FFFF);
    wr(9'h028, 32'hFFFF_FFFF);
    rd(O_SHI, "R11 hi unchanged", 32'hF000_0000);
    rd(O_SLC, "R11 loc unchanged", 32'h0);
    rd(O_FST, "R11 ctrl unchanged", 32'h45);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule